// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Square-Wave Output

This block sits beside a timekeeping counter. Each time the seconds field is updated it compares the current BCD time against a set of alarm registers and sets a sticky alarm flag when every unmasked field agrees. Three skip bits remove the minutes, hours and day/date fields from the comparison one by one. A selector chooses whether the day/date alarm byte is checked against the day of the week or the date of the month.

The block also divides a strobe that arrives on every edge of a 32.768 kHz oscillator, which is 65,536 strobes per second, with a free-running binary counter. A 2-bit rate code picks one counter bit as a square wave. A single output pin carries that square wave. When the interrupt mode is selected and the alarm is enabled, the pin is held low for as long as the flag is set.

Top module: `rtc_alarm_sqw`

## Requirements
- R1: While reset is high and on the first cycle after it, `alarm_flag` is 0 and the divider counter is 0, so with `int_mode` low `sqw_pin` is 0.
- R2: Every cycle with `half_tick` high advances the divider counter by one, wrapping at 2^DIV_W. With rate code 00 the pin is counter bit DIV_W-1. At the default DIV_W=16 this bit gives 1 Hz.
- R3: Rate code 01 puts counter bit 3 on the pin (4.096 kHz). Rate code 10 puts counter bit 2 on the pin (8.192 kHz). Rate code 11 puts counter bit 0 on the pin (32.768 kHz).
- R4: A match is evaluated only in a cycle where `sec_tick` is high, and only when `now_sec` equals 8'h00. With `sec_tick` low, or with any other seconds value, the flag is not set.
- R5: With all three skip bits set, every `sec_tick` at seconds 00 sets the flag, whatever the minutes, hours, day and date are. The alarm then fires once per minute.
- R6: With only `skip_min` clear, the flag is set only if `now_min` also equals `alm_min`.
- R7: With `skip_min` and `skip_hour` clear and `skip_dd` set, the flag is set only if both minutes and hours match.
- R8: With all skip bits clear and `dd_is_wday`=0, `alm_dd` is compared with `now_mday`, and `now_wday` is ignored.
- R9: With all skip bits clear and `dd_is_wday`=1, `alm_dd` is compared with `now_wday`, and `now_mday` is ignored.
- R10: Once set, the flag stays set until `flag_clr` is high. A clear in the same cycle as a new match leaves the flag set. The flag changes one cycle after the cycle that caused the change.
- R11: With `int_mode`=1 and `alarm_en`=1, `sqw_pin` is 0 in every cycle where the flag is set. When the flag is clear, the pin carries the selected square wave.
- R12: With `alarm_en`=0 or `int_mode`=0, the flag still sets, but `sqw_pin` carries the square wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_tick | input | 1 | Strobe on each 32.768 kHz oscillator edge |
| sec_tick | input | 1 | Strobe in the cycle the seconds field is updated |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_wday | input | 8 | Current day of week, BCD |
| now_mday | input | 8 | Current date of month, BCD |
| alm_min | input | 8 | Alarm minutes |
| alm_hour | input | 8 | Alarm hours |
| alm_dd | input | 8 | Alarm day-of-week or date |
| skip_min | input | 1 | 1: minutes not compared |
| skip_hour | input | 1 | 1: hours not compared |
| skip_dd | input | 1 | 1: day/date not compared |
| dd_is_wday | input | 1 | 0: compare date, 1: compare day of week |
| rate_sel | input | 2 | Square-wave rate code |
| alarm_en | input | 1 | Alarm may drive the pin |
| int_mode | input | 1 | 1: pin acts as active-low interrupt |
| flag_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Sticky alarm flag |
| sqw_pin | output | 1 | Square wave or active-low alarm |

## Verification
The bench builds the block with DIV_W=8, so the slowest rate code wraps after 256 strobes. A full period of the slow output, together with the three fast taps, therefore fits into a short run. Counter bits 0, 2 and 3 sit at the same positions as at the default width, so the fast rates are checked exactly as they would run in a chip. The alarm paths do not depend on the parameter, so every skip-bit combination named in the requirements is exercised.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef logic [7:0] bcd_t;

    typedef enum logic [1:0] {
        RATE_SLOW = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_FULL = 2'b11
    } rate_e;

    typedef struct packed {
        bcd_t secs;
        bcd_t mins;
        bcd_t hours;
        bcd_t wday;
        bcd_t mday;
    } clock_t;

    typedef struct packed {
        bcd_t mins;
        bcd_t hours;
        bcd_t dd;
        logic skip_min;
        logic skip_hour;
        logic skip_dd;
        logic use_wday;
    } alarm_cfg_t;

    localparam int NUM_FIELDS = 3;
    localparam bcd_t SEC_ROLL = 8'h00;

    // Counter bit that carries a given rate; the slow rate uses the top bit.
    function automatic int tap_index(rate_e r, int width);
        case (r)
            RATE_4K:   return 3;
            RATE_8K:   return 2;
            RATE_FULL: return 0;
            default:   return width - 1;
        endcase
    endfunction

    function automatic logic field_hit(bcd_t cur, bcd_t want, logic skip);
        return skip || (cur == want);
    endfunction

endpackage

// File: rtl/rtc_sqw_div.sv
module rtc_sqw_div
    import rtc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  half_tick,
    input  rate_e rate,
    output logic  wave
);
    localparam int TW = (DIV_W > 1) ? $clog2(DIV_W) : 1;

    logic [DIV_W-1:0] cnt;
    logic [TW-1:0]    tap;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (half_tick)
            cnt <= cnt + DIV_W'(1);
    end

    always_comb begin
        tap  = TW'(tap_index(rate, DIV_W));
        wave = cnt[tap];
    end

    a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
        half_tick |=> cnt == $past(cnt) + DIV_W'(1));

    a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
        !half_tick |=> $stable(cnt));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_tick,
    input  clock_t     now,
    input  alarm_cfg_t cfg,
    input  logic       clr,
    output logic       flag
);
    logic [NUM_FIELDS-1:0][7:0] cur_f;
    logic [NUM_FIELDS-1:0][7:0] ref_f;
    logic [NUM_FIELDS-1:0]      skip_f;
    logic [NUM_FIELDS-1:0]      ok;
    logic                       sec_zero;
    logic                       set_now;

    always_comb begin
        cur_f[0]  = now.mins;
        cur_f[1]  = now.hours;
        cur_f[2]  = cfg.use_wday ? now.wday : now.mday;
        ref_f[0]  = cfg.mins;
        ref_f[1]  = cfg.hours;
        ref_f[2]  = cfg.dd;
        skip_f[0] = cfg.skip_min;
        skip_f[1] = cfg.skip_hour;
        skip_f[2] = cfg.skip_dd;
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        assign ok[g] = field_hit(cur_f[g], ref_f[g], skip_f[g]);
    end

    assign sec_zero = (now.secs == SEC_ROLL);
    assign set_now  = sec_tick && sec_zero && (&ok);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set_now)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);

    a_r10_clear_works: assert property (@(posedge clk) disable iff (rst)
        clr && !set_now |=> !flag);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_now |=> flag);

    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> ($past(sec_tick) && $past(now.secs) == SEC_ROLL));

endmodule

// File: rtl/rtc_pin_sel.sv
module rtc_pin_sel (
    input  logic wave,
    input  logic flag,
    input  logic int_mode,
    input  logic alarm_en,
    output logic pin
);
    logic irq_active;

    assign irq_active = int_mode && alarm_en && flag;
    assign pin        = irq_active ? 1'b0 : wave;

endmodule

// File: rtl/rtc_alarm_sqw.sv
module rtc_alarm_sqw
    import rtc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       half_tick,
    input  logic       sec_tick,
    input  logic [7:0] now_sec,
    input  logic [7:0] now_min,
    input  logic [7:0] now_hour,
    input  logic [7:0] now_wday,
    input  logic [7:0] now_mday,
    input  logic [7:0] alm_min,
    input  logic [7:0] alm_hour,
    input  logic [7:0] alm_dd,
    input  logic       skip_min,
    input  logic       skip_hour,
    input  logic       skip_dd,
    input  logic       dd_is_wday,
    input  logic [1:0] rate_sel,
    input  logic       alarm_en,
    input  logic       int_mode,
    input  logic       flag_clr,
    output logic       alarm_flag,
    output logic       sqw_pin
);
    clock_t     now;
    alarm_cfg_t cfg;
    logic       wave;

    always_comb begin
        now.secs      = now_sec;
        now.mins      = now_min;
        now.hours     = now_hour;
        now.wday      = now_wday;
        now.mday      = now_mday;
        cfg.mins      = alm_min;
        cfg.hours     = alm_hour;
        cfg.dd        = alm_dd;
        cfg.skip_min  = skip_min;
        cfg.skip_hour = skip_hour;
        cfg.skip_dd   = skip_dd;
        cfg.use_wday  = dd_is_wday;
    end

    rtc_alarm_match u_match (
        .clk      (clk),
        .rst      (rst),
        .sec_tick (sec_tick),
        .now      (now),
        .cfg      (cfg),
        .clr      (flag_clr),
        .flag     (alarm_flag)
    );

    rtc_sqw_div #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .half_tick (half_tick),
        .rate      (rate_e'(rate_sel)),
        .wave      (wave)
    );

    rtc_pin_sel u_pin (
        .wave     (wave),
        .flag     (alarm_flag),
        .int_mode (int_mode),
        .alarm_en (alarm_en),
        .pin      (sqw_pin)
    );

    a_r11_pin_low_on_alarm: assert property (@(posedge clk) disable iff (rst)
        int_mode && alarm_en && alarm_flag |-> !sqw_pin);

endmodule

// File: tb/test_rtc_alarm_sqw.sv
module test_rtc_alarm_sqw;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic half_tick = 1'b0, sec_tick = 1'b0;
    logic [7:0] now_sec = 8'h00, now_min = 8'h00, now_hour = 8'h00;
    logic [7:0] now_wday = 8'h01, now_mday = 8'h01;
    logic [7:0] alm_min = 8'h00, alm_hour = 8'h00, alm_dd = 8'h00;
    logic skip_min = 1'b1, skip_hour = 1'b1, skip_dd = 1'b1, dd_is_wday = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic alarm_en = 1'b0, int_mode = 1'b0, flag_clr = 1'b0;
    logic alarm_flag, sqw_pin;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    int m_cnt = 0;
    bit m_flag = 1'b0;

    always #4 clk = ~clk;

    rtc_alarm_sqw #(.DIV_W(CW)) i_rtc_alarm_sqw (
        .clk(clk), .rst(rst), .half_tick(half_tick), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
        .now_wday(now_wday), .now_mday(now_mday),
        .alm_min(alm_min), .alm_hour(alm_hour), .alm_dd(alm_dd),
        .skip_min(skip_min), .skip_hour(skip_hour), .skip_dd(skip_dd),
        .dd_is_wday(dd_is_wday), .rate_sel(rate_sel), .alarm_en(alarm_en),
        .int_mode(int_mode), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .sqw_pin(sqw_pin)
    );

    function automatic bit model_hit();
        bit res;
        if (now_sec != 8'h00) return 1'b0;
        res = 1'b1;
        if (!skip_dd) begin
            if (dd_is_wday) res = res && (now_wday == alm_dd);
            else            res = res && (now_mday == alm_dd);
        end
        if (!skip_hour) res = res && (now_hour == alm_hour);
        if (!skip_min)  res = res && (now_min == alm_min);
        return res;
    endfunction

    function automatic bit model_pin();
        int idx;
        case (rate_sel)
            2'b01:   idx = 3;
            2'b10:   idx = 2;
            2'b11:   idx = 0;
            default: idx = CW - 1;
        endcase
        if (int_mode && alarm_en && m_flag) return 1'b0;
        return 1'((m_cnt >> idx) & 1);
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced on every clock
    always @(posedge clk) begin
        if (rst) begin
            m_cnt  = 0;
            m_flag = 1'b0;
        end else begin
            if (sec_tick && model_hit()) m_flag = 1'b1;
            else if (flag_clr)           m_flag = 1'b0;
            if (half_tick) m_cnt = (m_cnt + 1) % (1 << CW);
        end
    end

    always begin
        @(posedge clk);
        #2;
        if (!done) begin
            chk(alarm_flag, m_flag, cur_req, "flag vs model");
            chk(sqw_pin, model_pin(), cur_req, "pin vs model");
        end
    end

    task automatic fire(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] wd, input logic [7:0] md,
                        input logic exp, input string req);
        now_sec = s; now_min = m; now_hour = h; now_wday = wd; now_mday = md;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk(alarm_flag, exp, req, "flag after seconds tick");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(alarm_flag, 1'b0, "R10", "flag after clear");
    endtask

    task automatic run_ticks(input int cycles, input int every);
        for (int i = 0; i < cycles; i++) begin
            half_tick = (i % every == 0);
            @(negedge clk);
        end
        half_tick = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(alarm_flag, 1'b0, "R1", "flag in reset");
        chk(sqw_pin, 1'b0, "R1", "pin in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(alarm_flag, 1'b0, "R1", "flag after reset");
        chk(sqw_pin, 1'b0, "R1", "pin after reset");

        // R2: slow tap over a full wrap
        cur_req = "R2";
        rate_sel = 2'b00;
        run_ticks(1 << (CW - 1), 1);
        chk(sqw_pin, 1'b1, "R2", "slow tap after half wrap");
        run_ticks(1 << (CW - 1), 1);
        chk(sqw_pin, 1'b0, "R2", "slow tap after full wrap");

        // R3: fast taps
        cur_req = "R3";
        rate_sel = 2'b01; run_ticks(80, 2);
        rate_sel = 2'b10; run_ticks(60, 1);
        rate_sel = 2'b11; run_ticks(40, 3);

        // R4: no evaluation without tick or off the minute
        cur_req = "R4";
        skip_min = 1'b1; skip_hour = 1'b1; skip_dd = 1'b1;
        fire(8'h30, 8'h10, 8'h05, 8'h02, 8'h11, 1'b0, "R4");
        now_sec = 8'h00;
        repeat (4) @(negedge clk);
        chk(alarm_flag, 1'b0, "R4", "no tick no flag");

        // R5: once per minute
        cur_req = "R5";
        fire(8'h00, 8'h37, 8'h22, 8'h06, 8'h29, 1'b1, "R5");
        fire(8'h00, 8'h01, 8'h09, 8'h03, 8'h02, 1'b1, "R5");

        // R6: minutes
        cur_req = "R6";
        skip_min = 1'b0; alm_min = 8'h45;
        fire(8'h00, 8'h44, 8'h07, 8'h01, 8'h03, 1'b0, "R6");
        fire(8'h00, 8'h45, 8'h07, 8'h01, 8'h03, 1'b1, "R6");

        // R7: hours and minutes
        cur_req = "R7";
        skip_hour = 1'b0; alm_hour = 8'h13;
        fire(8'h00, 8'h45, 8'h12, 8'h01, 8'h03, 1'b0, "R7");
        fire(8'h00, 8'h45, 8'h13, 8'h01, 8'h03, 1'b1, "R7");
        fire(8'h00, 8'h46, 8'h13, 8'h01, 8'h03, 1'b0, "R7");

        // R8: date of month
        cur_req = "R8";
        skip_dd = 1'b0; dd_is_wday = 1'b0; alm_dd = 8'h05;
        fire(8'h00, 8'h45, 8'h13, 8'h05, 8'h20, 1'b0, "R8");
        fire(8'h00, 8'h45, 8'h13, 8'h02, 8'h05, 1'b1, "R8");

        // R9: day of week
        cur_req = "R9";
        dd_is_wday = 1'b1;
        fire(8'h00, 8'h45, 8'h13, 8'h02, 8'h05, 1'b0, "R9");
        fire(8'h00, 8'h45, 8'h13, 8'h05, 8'h17, 1'b1, "R9");

        // R10: stickiness and set-over-clear
        cur_req = "R10";
        now_sec = 8'h00; now_wday = 8'h05; sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        now_sec = 8'h01;
        repeat (5) @(negedge clk);
        chk(alarm_flag, 1'b1, "R10", "flag holds");
        now_sec = 8'h00; sec_tick = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0; flag_clr = 1'b0;
        chk(alarm_flag, 1'b1, "R10", "set wins over clear");
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        chk(alarm_flag, 1'b0, "R10", "clear alone");

        // R11: interrupt mode drives pin low
        cur_req = "R11";
        rate_sel = 2'b11; int_mode = 1'b1; alarm_en = 1'b1;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        for (int i = 0; i < 6; i++) begin
            half_tick = 1'b1;
            @(negedge clk);
            chk(sqw_pin, 1'b0, "R11", "pin low while flagged");
        end
        half_tick = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        run_ticks(10, 1);

        // R12: alarm disabled, wave continues while flagged
        cur_req = "R12";
        alarm_en = 1'b0;
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk(alarm_flag, 1'b1, "R12", "flag sets while disabled");
        run_ticks(12, 1);
        chk(sqw_pin, 1'(m_cnt & 1), "R12", "pin follows wave");
        int_mode = 1'b0; alarm_en = 1'b1;
        run_ticks(12, 2);
        chk(sqw_pin, 1'(m_cnt & 1), "R12", "square mode ignores flag");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule